// File: doc/BRIEF.md
# Cascaded 32-Request Priority Encoder

This block takes 32 request lines and an enable, and reports the number of the highest-numbered request that is set. It is built from four identical 8-request encoder slices. The slices form a chain through their enable inputs. The slice holding requests 31 down to 24 sits at the top of the chain. Each lower slice is enabled only through the "all idle" output of the slice directly above it. As a result, at most one slice ever claims a request.

The 5-bit result is put together from the slice outputs. The two upper bits name the slice that holds a request: 3 for requests 31..24, down to 0 for requests 7..0. The three lower bits are the OR of the slice indices, since a slice that holds no request drives an index of 0. Two flags come with the result. The "found" flag is set when the block is enabled and some request is set. The "none" flag is set when the block is enabled and every request is clear.

The block has no clock and no state. The outputs follow the inputs through combinational logic only. There are no states or transitions to name.

Top module: `cascade_prio_enc`

## Requirements
- R1: With en_i=1, index_o equals i when req_i[i]=1 and every req_i bit above i is 0. Higher request numbers win, whatever the lower bits hold.
- R2: found_o is 1 exactly when en_i=1 and at least one bit of req_i is 1.
- R3: none_o is 1 exactly when en_i=1 and every bit of req_i is 0.
- R4: With en_i=0, index_o=0, found_o=0 and none_o=0 for any req_i.
- R5: With en_i=1 and req_i=0, index_o=0, found_o=0 and none_o=1.
- R6: index_o[4:3] is the number of the slice holding the winning request (3 for bits 31..24, 2 for 23..16, 1 for 15..8, 0 for 7..0). index_o[2:0] is the winner's position within that slice.
- R7: A slice is enabled only when every slice above it holds no request. A request anywhere in a higher slice therefore hides every request in the lower slices, and at most one slice reports a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| en_i | input | 1 | Global enable; drives the top slice of the chain |
| req_i | input | 32 | Request lines; bit 31 has the highest priority |
| index_o | output | 5 | Number of the highest set request |
| found_o | output | 1 | Enabled and at least one request is set |
| none_o | output | 1 | Enabled and no request is set |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and the outputs. The bench changes en_i and req_i just after a rising edge. It reads the outputs at the following falling edge, half a period later, when the chain has settled. It compares them with a reference written from the requirements. The stimulus covers every pattern of each slice on its own, walking ones with and without noise in the lower bits, random words, and both enable values.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
    // Default geometry of the cascade
    localparam int CPE_SLICE_W = 8;   // requests per slice
    localparam int CPE_SLICE_N = 4;   // slices in the chain
endpackage

// File: rtl/cpe_slice.sv
// One priority encoder slice: highest set request wins.
module cpe_slice #(
    parameter int SLICE_W = cpe_pkg::CPE_SLICE_W,
    localparam int IDX_W  = $clog2(SLICE_W)
) (
    input  logic               en_i,
    input  logic [SLICE_W-1:0] req_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               gs_o,
    output logic               idle_o
);
    logic any_req;
    logic [IDX_W-1:0] win;

    // Scan upward so the highest set bit is the last assignment
    always_comb begin
        win = '0;
        for (int b = 0; b < SLICE_W; b++) begin
            if (req_i[b]) win = IDX_W'(b);
        end
    end

    assign any_req = |req_i;
    assign gs_o    = en_i & any_req;
    assign idle_o  = en_i & ~any_req;
    assign idx_o   = gs_o ? win : '0;

    always_comb begin
        // R2/R3: a slice never claims and reports idle at once
        assert_gs_idle_excl_R3: assert (!(gs_o && idle_o))
            else $error("slice gs and idle both high");
        // R1: a reported index points at a set request with nothing set above it
        if (gs_o) begin
            assert_idx_is_winner_R1: assert (req_i[idx_o] && ((req_i >> idx_o) >> 1) == '0)
                else $error("slice index is not the top request");
        end
        // R4: no request reported means index 0
        if (!gs_o) begin
            assert_idx_zero_idle_R4: assert (idx_o == '0)
                else $error("slice index nonzero while not claiming");
        end
    end
endmodule

// File: rtl/cpe_chain.sv
// Chains the slices: each lower slice is enabled by the idle flag above it.
module cpe_chain #(
    parameter int SLICE_W = cpe_pkg::CPE_SLICE_W,
    parameter int SLICE_N = cpe_pkg::CPE_SLICE_N,
    localparam int IDX_W  = $clog2(SLICE_W),
    localparam int REQ_W  = SLICE_W * SLICE_N
) (
    input  logic                            en_i,
    input  logic [REQ_W-1:0]                req_i,
    output logic [SLICE_N-1:0][IDX_W-1:0]   idx_o,
    output logic [SLICE_N-1:0]              gs_o,
    output logic                            idle_o
);
    // en_link[SLICE_N] is the global enable; en_link[s] enables slice s-1
    logic [SLICE_N:0] en_link;

    assign en_link[SLICE_N] = en_i;

    for (genvar s = SLICE_N - 1; s >= 0; s--) begin : g_slice
        cpe_slice #(.SLICE_W(SLICE_W)) u_slice (
            .en_i  (en_link[s+1]),
            .req_i (req_i[s*SLICE_W +: SLICE_W]),
            .idx_o (idx_o[s]),
            .gs_o  (gs_o[s]),
            .idle_o(en_link[s])
        );
    end

    assign idle_o = en_link[0];

    always_comb begin
        // R7: at most one slice claims a request
        assert_one_group_R7: assert ($onehot0(gs_o))
            else $error("more than one slice claims a request");
    end
endmodule

// File: rtl/cpe_merge.sv
// Builds the wide index: slice number on top, OR of slice indices below.
module cpe_merge #(
    parameter int SLICE_W = cpe_pkg::CPE_SLICE_W,
    parameter int SLICE_N = cpe_pkg::CPE_SLICE_N,
    localparam int IDX_W  = $clog2(SLICE_W),
    localparam int SEL_W  = $clog2(SLICE_N)
) (
    input  logic [SLICE_N-1:0][IDX_W-1:0] idx_i,
    input  logic [SLICE_N-1:0]            gs_i,
    output logic [SEL_W+IDX_W-1:0]        index_o,
    output logic                          found_o
);
    logic [SEL_W-1:0] sel;
    logic [IDX_W-1:0] low;

    always_comb begin
        sel = '0;
        low = '0;
        for (int s = 0; s < SLICE_N; s++) begin
            if (gs_i[s]) sel = SEL_W'(s);
            low = low | idx_i[s];
        end
    end

    assign index_o = {sel, low};
    assign found_o = |gs_i;
endmodule

// File: rtl/cascade_prio_enc.sv
module cascade_prio_enc #(
    parameter int SLICE_W = cpe_pkg::CPE_SLICE_W,
    parameter int SLICE_N = cpe_pkg::CPE_SLICE_N
) (
    input  logic                                  en_i,
    input  logic [SLICE_W*SLICE_N-1:0]            req_i,
    output logic [$clog2(SLICE_W*SLICE_N)-1:0]    index_o,
    output logic                                  found_o,
    output logic                                  none_o
);
    localparam int IDX_W = $clog2(SLICE_W);

    logic [SLICE_N-1:0][IDX_W-1:0] slice_idx;
    logic [SLICE_N-1:0]            slice_gs;

    cpe_chain #(.SLICE_W(SLICE_W), .SLICE_N(SLICE_N)) u_chain (
        .en_i  (en_i),
        .req_i (req_i),
        .idx_o (slice_idx),
        .gs_o  (slice_gs),
        .idle_o(none_o)
    );

    cpe_merge #(.SLICE_W(SLICE_W), .SLICE_N(SLICE_N)) u_merge (
        .idx_i  (slice_idx),
        .gs_i   (slice_gs),
        .index_o(index_o),
        .found_o(found_o)
    );

    always_comb begin
        // R4: disabled block reports nothing
        if (!en_i) begin
            assert_disabled_quiet_R4: assert (!found_o && !none_o && index_o == '0)
                else $error("outputs active while disabled");
        end
        // R2: found and none never both set
        assert_found_none_excl_R2: assert (!(found_o && none_o))
            else $error("found and none both high");
        // R1: the reported index names a set request
        if (found_o) begin
            assert_index_hits_req_R1: assert (req_i[index_o])
                else $error("index does not name a set request");
        end
    end
endmodule

// File: tb/sim_cascade_prio_enc.sv
module sim_cascade_prio_enc;
    logic        clk = 1'b0;
    logic        en_i = 1'b0;
    logic [31:0] req_i = '0;
    logic [4:0]  index_o;
    logic        found_o, none_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    cascade_prio_enc u0 (
        .en_i(en_i), .req_i(req_i),
        .index_o(index_o), .found_o(found_o), .none_o(none_o)
    );

    // Reference taken from the requirements
    function automatic logic [6:0] ref_model(input logic en, input logic [31:0] r);
        logic [4:0] idx = '0;
        logic hit = 1'b0;
        for (int i = 31; i >= 0; i--) begin
            if (!hit && r[i]) begin
                idx = 5'(i);
                hit = 1'b1;
            end
        end
        if (!en) return 7'b0;
        return {idx, hit, ~hit};
    endfunction

    // Drive after a rising edge, compare at the falling edge
    task automatic apply(input logic en, input logic [31:0] r, input string tag);
        logic [6:0] exp;
        @(posedge clk);
        en_i  = en;
        req_i = r;
        @(negedge clk);
        exp = ref_model(en, r);
        checks++;
        if ({index_o, found_o, none_o} !== exp) begin
            errors++;
            $display("FAIL %s en=%0b req=%h: got index=%0d found=%0b none=%0b, expected index=%0d found=%0b none=%0b",
                     tag, en, r, index_o, found_o, none_o, exp[6:2], exp[1], exp[0]);
        end
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        checks++;
        if (index_o !== 5'd0 || found_o !== 1'b0 || none_o !== 1'b0) begin
            errors++;
            $display("FAIL R4 initial state: got %0d/%0b/%0b expected 0/0/0",
                     index_o, found_o, none_o);
        end
    endtask

    task automatic t_disabled;
        apply(1'b0, 32'hFFFF_FFFF, "R4 disabled all ones");
        apply(1'b0, 32'h0000_0000, "R4 disabled idle");
        for (int k = 0; k < 200; k++) apply(1'b0, $urandom, "R4 disabled random");
    endtask

    task automatic t_idle;
        apply(1'b1, 32'h0, "R5 enabled no requests");
        apply(1'b1, 32'h0, "R3 none flag");
    endtask

    task automatic t_walking;
        for (int i = 0; i < 32; i++) apply(1'b1, 32'h1 << i, "R6 walking one slice field");
        for (int i = 0; i < 32; i++) begin
            logic [31:0] noise = $urandom;
            logic [31:0] mask  = (i == 0) ? 32'h0 : ((32'h1 << i) - 1);
            apply(1'b1, (32'h1 << i) | (noise & mask), "R1 walking one with lower noise");
        end
    endtask

    task automatic t_slice_exhaustive;
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 256; p++)
                apply(1'b1, 32'(p) << (8 * s), "R2 per-slice exhaustive");
    endtask

    task automatic t_masking;
        apply(1'b1, 32'h8000_00FF, "R7 top bit hides lower slices");
        apply(1'b1, 32'h0100_FFFF, "R7 bit 24 hides lower slices");
        apply(1'b1, 32'h0001_0101, "R7 bit 16 wins");
        apply(1'b1, 32'h0000_8001, "R7 bit 15 wins");
        apply(1'b1, 32'hFFFF_FFFF, "R1 all ones");
    endtask

    task automatic t_random;
        for (int k = 0; k < 2000; k++) apply(1'b1, $urandom, "R1 random enabled");
        for (int k = 0; k < 500; k++)  apply(k[0], $urandom >> (k % 32), "R2 random sparse");
    endtask

    initial begin
        t_reset_state();
        t_disabled();
        t_idle();
        t_walking();
        t_slice_exhaustive();
        t_masking();
        t_random();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired: got running, expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule